// File: doc/BRIEF.md
# Video Resolution and Stability Detector

This block sits on a clocked video timing stream and works out the incoming format. It takes the active-video enable, horizontal sync, vertical sync, a field indicator and a lock flag, all in one clock domain. From these it measures two things per line, the active samples and the total samples. It also measures, for each of the two field polarities, the active lines and the total lines. It then decides whether the line length has settled and whether the stream is interlaced.

Each measurement is published as soon as it is known, and each has its own valid flag in a status word. Until a value is valid, its register returns a default value set at build time. Software reaches the block through a small word-addressed read/write port. A single interrupt line reports changes of stability and changes of resolution. The two interrupt sources can be enabled separately and are cleared by writing 1.

Top module: `vid_fmt_detect`

## Requirements
- R1: The stable flag (status bit 0) is 1 exactly when, among the three most recently completed lines, at least two have equal total sample counts; it is re-evaluated at each line completion.
- R2: While `vid_lock` is 0, the block forces stable, interlaced, resolution-valid and every measurement-valid flag to 0, and ignores sync and enable activity. Once lock returns, detection restarts: the first horizontal sync rising edge opens a line, and the next one completes it.
- R3: A line runs from one rising edge of `vid_hs` to the next. Its total sample count is the number of clock cycles in that span, and its active count is the number of those cycles with `vid_de` high. Reads of address 3 return the active count of the last completed line, and reads of address 4 return its total count.
- R4: A field runs from one rising edge of `vid_vs` to the next. Its polarity is the value of `vid_fld` in the cycle of the opening edge. Its total lines are the `vid_hs` rising edges inside it, including one that coincides with the opening edge. Its active lines are the `vid_de` rising edges inside it. Addresses 5 and 6 return active lines of polarity 0 and 1; addresses 7 and 8 return their total lines.
- R5: Status bit 1 (interlaced) is set when a field opens whose polarity differs from that of the field just completed. Status bit 2 (resolution valid) is set when a second complete field ends.
- R6: Status bit 3 is set at the first completed line. Status bits 4 and 5 are set when a field of polarity 0 or 1, respectively, completes.
- R7: While a measurement's valid flag is 0, its register returns the default parameter (1920 active samples, 2200 total samples, 540 active lines, 563 and 562 total lines for polarity 0 and 1).
- R8: Pending bit 1 of the interrupt word (address 2) is set when resolution valid rises. It is also set when, with resolution valid set, a completed line or field measures differently from the stored value. Pending bit 2 is set on every change of the stable flag, in either direction.
- R9: Control word bits [2:1] (address 0) enable pending bits [2:1] respectively. `irq_o` is high when any pending bit is also enabled.
- R10: Writing address 2 clears each pending bit whose write-data bit is 1. If a new event arrives in the same cycle, the bit stays set.
- R11: A read strobe on `reg_rd` returns the addressed word on `reg_rdata` with `reg_rvalid` high in the following cycle. A write strobe on `reg_wr` takes effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_de | input | 1 | Active-video enable |
| vid_hs | input | 1 | Horizontal sync, rising edge starts a line |
| vid_vs | input | 1 | Vertical sync, rising edge starts a field |
| vid_fld | input | 1 | Field polarity indicator |
| vid_lock | input | 1 | Source locked indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: 16-bit counters and build-time defaults of 1920, 2200, 540, 563 and 562. It then drives very short synthetic lines of 7 to 14 samples and fields of 4 to 5 lines. Because the measured values are far from the defaults, any read shows at once whether a register is returning a measurement or a default. The short lines also make it cheap to produce every pattern the two-of-three history can hold: all equal, one outlier, and all different. Register accesses pause the stream and stretch the line in progress. The expected history therefore includes these long lines, which exercises matches between the newest and oldest entries.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int HIST   = 3;
    localparam int NFLD   = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    // one measurement pair: active part and total
    typedef struct packed {
        cnt_t act;
        cnt_t tot;
    } span_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL     = 4'd0,
        A_STAT     = 4'd1,
        A_IRQ      = 4'd2,
        A_ACT_SAMP = 4'd3,
        A_TOT_SAMP = 4'd4,
        A_F0_ACT   = 4'd5,
        A_F1_ACT   = 4'd6,
        A_F0_TOT   = 4'd7,
        A_F1_TOT   = 4'd8
    } reg_addr_e;

    function automatic cnt_t sat_inc(cnt_t v);
        return (&v) ? v : v + cnt_t'(1);
    endfunction

    // a = newest, c = oldest, n = entries held
    function automatic logic two_of_three(cnt_t a, cnt_t b, cnt_t c, logic [1:0] n);
        return (n >= 2'd2 && a == b) || (n == 2'd3 && (a == c || b == c));
    endfunction

endpackage

// File: rtl/vfd_line_meas.sv
module vfd_line_meas
    import vfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lock,
    input  logic  de,
    input  logic  hs,
    output logic  done,
    output span_t meas,
    output logic  stable
);

    logic       hs_q;
    logic       started;
    cnt_t       tot_c;
    cnt_t       act_c;
    cnt_t       hist [HIST];
    logic [1:0] n_hist;
    logic [1:0] n_new;
    logic       hs_rise;

    assign hs_rise = hs & ~hs_q;
    assign n_new   = (n_hist == 2'd3) ? 2'd3 : n_hist + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q    <= 1'b0;
            started <= 1'b0;
            tot_c   <= '0;
            act_c   <= '0;
            n_hist  <= '0;
            stable  <= 1'b0;
            done    <= 1'b0;
            meas    <= '0;
            for (int i = 0; i < HIST; i++) hist[i] <= '0;
        end else begin
            hs_q <= hs;
            done <= 1'b0;
            if (!lock) begin
                started <= 1'b0;
                tot_c   <= '0;
                act_c   <= '0;
                n_hist  <= '0;
                stable  <= 1'b0;
                for (int i = 0; i < HIST; i++) hist[i] <= '0;
            end else if (hs_rise) begin
                tot_c   <= cnt_t'(1);
                act_c   <= de ? cnt_t'(1) : '0;
                started <= 1'b1;
                if (started) begin
                    done     <= 1'b1;
                    meas.act <= act_c;
                    meas.tot <= tot_c;
                    hist[0]  <= tot_c;
                    for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
                    n_hist   <= n_new;
                    stable   <= two_of_three(tot_c, hist[0], hist[1], n_new);
                end
            end else begin
                tot_c <= sat_inc(tot_c);
                if (de) act_c <= sat_inc(act_c);
            end
        end
    end

endmodule

// File: rtl/vfd_field_meas.sv
module vfd_field_meas
    import vfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lock,
    input  logic  de,
    input  logic  hs,
    input  logic  vs,
    input  logic  fld,
    output logic  done,
    output logic  done_fld,
    output span_t meas,
    output logic  ilace,
    output logic  res_ok
);

    logic hs_q, vs_q, de_q;
    logic started, seen, cur_fld;
    cnt_t tot_c, act_c;
    logic hs_rise, vs_rise, de_rise;

    assign hs_rise = hs & ~hs_q;
    assign vs_rise = vs & ~vs_q;
    assign de_rise = de & ~de_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q     <= 1'b0;
            vs_q     <= 1'b0;
            de_q     <= 1'b0;
            started  <= 1'b0;
            seen     <= 1'b0;
            cur_fld  <= 1'b0;
            tot_c    <= '0;
            act_c    <= '0;
            done     <= 1'b0;
            done_fld <= 1'b0;
            meas     <= '0;
            ilace    <= 1'b0;
            res_ok   <= 1'b0;
        end else begin
            hs_q <= hs;
            vs_q <= vs;
            de_q <= de;
            done <= 1'b0;
            if (!lock) begin
                started <= 1'b0;
                seen    <= 1'b0;
                ilace   <= 1'b0;
                res_ok  <= 1'b0;
                tot_c   <= '0;
                act_c   <= '0;
            end else if (vs_rise) begin
                if (started) begin
                    done     <= 1'b1;
                    done_fld <= cur_fld;
                    meas.act <= act_c;
                    meas.tot <= tot_c;
                    seen     <= 1'b1;
                    if (seen) res_ok <= 1'b1;
                    if (fld != cur_fld) ilace <= 1'b1;
                end
                started <= 1'b1;
                cur_fld <= fld;
                tot_c   <= hs_rise ? cnt_t'(1) : '0;
                act_c   <= de_rise ? cnt_t'(1) : '0;
            end else begin
                if (hs_rise) tot_c <= sat_inc(tot_c);
                if (de_rise) act_c <= sat_inc(act_c);
            end
        end
    end

endmodule

// File: rtl/vfd_regs.sv
module vfd_regs
    import vfd_pkg::*;
#(
    parameter int DEF_ACT_SAMP  = 1920,
    parameter int DEF_TOT_SAMP  = 2200,
    parameter int DEF_ACT_LINES = 540,
    parameter int DEF_F0_TOT    = 563,
    parameter int DEF_F1_TOT    = 562
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  logic              line_done,
    input  span_t             line_meas,
    input  logic              stable,
    input  logic              fld_done,
    input  logic              fld_id,
    input  span_t             fld_meas,
    input  logic              ilace,
    input  logic              res_ok,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              irq_o,
    output logic              samp_v,
    output logic [NFLD-1:0]   fv,
    output logic [2:1]        pend,
    output logic              upd_evt
);

    localparam cnt_t DEF_TOT [NFLD] = '{cnt_t'(DEF_F0_TOT), cnt_t'(DEF_F1_TOT)};

    logic [2:1]        en;
    logic [2:1]        wclr;
    span_t             samp;
    logic              stab_q, res_q, stab_evt;
    span_t             fstore [NFLD];
    logic [NFLD-1:0]   fdiff;
    cnt_t              f_act [NFLD];
    cnt_t              f_tot [NFLD];
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^{reg_wdata[DATA_W-1:3], reg_wdata[0]};

    // one storage slot per field polarity
    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        span_t st_q;
        logic  v_q;
        always_ff @(posedge clk) begin
            if (rst || !lock) begin
                st_q <= '0;
                v_q  <= 1'b0;
            end else if (fld_done && fld_id == 1'(g)) begin
                st_q <= fld_meas;
                v_q  <= 1'b1;
            end
        end
        assign fstore[g] = st_q;
        assign fv[g]     = v_q;
        assign fdiff[g]  = fld_done && fld_id == 1'(g) && v_q && fld_meas != st_q;
        assign f_act[g]  = v_q ? st_q.act : cnt_t'(DEF_ACT_LINES);
        assign f_tot[g]  = v_q ? st_q.tot : DEF_TOT[g];
    end

    assign stab_evt = stable ^ stab_q;
    assign upd_evt  = res_ok && (!res_q || (line_done && samp_v && line_meas != samp) || (|fdiff));
    assign wclr     = (reg_wr && reg_addr == A_IRQ) ? reg_wdata[2:1] : 2'b00;
    assign irq_o    = |(pend & en);

    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_CTRL:     rd_mux[2:1] = en;
            A_STAT:     rd_mux[5:0] = {fv[1], fv[0], samp_v, res_ok, ilace, stable};
            A_IRQ:      rd_mux[2:1] = pend;
            A_ACT_SAMP: rd_mux = DATA_W'(samp_v ? samp.act : cnt_t'(DEF_ACT_SAMP));
            A_TOT_SAMP: rd_mux = DATA_W'(samp_v ? samp.tot : cnt_t'(DEF_TOT_SAMP));
            A_F0_ACT:   rd_mux = DATA_W'(f_act[0]);
            A_F1_ACT:   rd_mux = DATA_W'(f_act[1]);
            A_F0_TOT:   rd_mux = DATA_W'(f_tot[0]);
            A_F1_TOT:   rd_mux = DATA_W'(f_tot[1]);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en         <= '0;
            pend       <= '0;
            samp_v     <= 1'b0;
            samp       <= '0;
            stab_q     <= 1'b0;
            res_q      <= 1'b0;
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            stab_q     <= stable;
            res_q      <= res_ok;
            reg_rvalid <= reg_rd;
            if (!lock) begin
                samp_v <= 1'b0;
            end else if (line_done) begin
                samp_v <= 1'b1;
                samp   <= line_meas;
            end
            if (reg_wr && reg_addr == A_CTRL) en <= reg_wdata[2:1];
            pend <= (pend & ~wclr) | {stab_evt, upd_evt};
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/vid_fmt_detect.sv
module vid_fmt_detect
    import vfd_pkg::*;
#(
    parameter int DEF_ACT_SAMP  = 1920,
    parameter int DEF_TOT_SAMP  = 2200,
    parameter int DEF_ACT_LINES = 540,
    parameter int DEF_F0_TOT    = 563,
    parameter int DEF_F1_TOT    = 562
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vid_de,
    input  logic              vid_hs,
    input  logic              vid_vs,
    input  logic              vid_fld,
    input  logic              vid_lock,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              irq_o
);

    logic            line_done_w, stable_w;
    span_t           line_meas_w;
    logic            fld_done_w, fld_id_w, ilace_w, res_w;
    span_t           fld_meas_w;
    logic            samp_v_w, upd_evt_w;
    logic [NFLD-1:0] fv_w;
    logic [2:1]      pend_w;

    vfd_line_meas u_line (
        .clk    (clk),
        .rst    (rst),
        .lock   (vid_lock),
        .de     (vid_de),
        .hs     (vid_hs),
        .done   (line_done_w),
        .meas   (line_meas_w),
        .stable (stable_w)
    );

    vfd_field_meas u_field (
        .clk      (clk),
        .rst      (rst),
        .lock     (vid_lock),
        .de       (vid_de),
        .hs       (vid_hs),
        .vs       (vid_vs),
        .fld      (vid_fld),
        .done     (fld_done_w),
        .done_fld (fld_id_w),
        .meas     (fld_meas_w),
        .ilace    (ilace_w),
        .res_ok   (res_w)
    );

    vfd_regs #(
        .DEF_ACT_SAMP  (DEF_ACT_SAMP),
        .DEF_TOT_SAMP  (DEF_TOT_SAMP),
        .DEF_ACT_LINES (DEF_ACT_LINES),
        .DEF_F0_TOT    (DEF_F0_TOT),
        .DEF_F1_TOT    (DEF_F1_TOT)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .lock       (vid_lock),
        .line_done  (line_done_w),
        .line_meas  (line_meas_w),
        .stable     (stable_w),
        .fld_done   (fld_done_w),
        .fld_id     (fld_id_w),
        .fld_meas   (fld_meas_w),
        .ilace      (ilace_w),
        .res_ok     (res_w),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .irq_o      (irq_o),
        .samp_v     (samp_v_w),
        .fv         (fv_w),
        .pend       (pend_w),
        .upd_evt    (upd_evt_w)
    );

endmodule

// File: rtl/vfd_checker.sv
module vfd_checker
    import vfd_pkg::*;
#(
    parameter int DEF_ACT_SAMP = 1920
) (
    input logic              clk,
    input logic              rst,
    input logic              vid_lock,
    input logic              stable,
    input logic              samp_v,
    input logic              ilace,
    input logic              res_ok,
    input logic [NFLD-1:0]   fv,
    input logic [2:1]        pend,
    input logic              upd_evt,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              clr_upd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              reg_rvalid
);

    p_stable_needs_line_r1: assert property (@(posedge clk) disable iff (rst)
        stable |-> samp_v);

    p_unlock_clears_r2: assert property (@(posedge clk) disable iff (rst)
        !vid_lock |=> (!stable && !samp_v && !ilace && !res_ok && fv == '0));

    p_res_needs_field_r5: assert property (@(posedge clk) disable iff (rst)
        res_ok |-> (fv != '0));

    p_default_shown_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_ACT_SAMP && !samp_v) |=> reg_rdata == DATA_W'(DEF_ACT_SAMP));

    p_stab_pending_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(stable) || $fell(stable)) |=> pend[2]);

    p_write_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_IRQ && clr_upd && !upd_evt) |=> !pend[1]);

    p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);

endmodule

bind vid_fmt_detect vfd_checker #(.DEF_ACT_SAMP(DEF_ACT_SAMP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .vid_lock   (vid_lock),
    .stable     (stable_w),
    .samp_v     (samp_v_w),
    .ilace      (ilace_w),
    .res_ok     (res_w),
    .fv         (fv_w),
    .pend       (pend_w),
    .upd_evt    (upd_evt_w),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .clr_upd    (reg_wdata[1]),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
);

// File: tb/vid_fmt_detect_tb_top.sv
module vid_fmt_detect_tb_top;
    import vfd_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic              vid_de, vid_hs, vid_vs, vid_fld, vid_lock;
    logic              reg_wr, reg_rd;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic              reg_rvalid;
    logic              irq_o;

    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] exp;
        string             tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    ended  = 1'b0;

    vid_fmt_detect dut_i (
        .clk        (clk),
        .rst        (rst),
        .vid_de     (vid_de),
        .vid_hs     (vid_hs),
        .vid_vs     (vid_vs),
        .vid_fld    (vid_fld),
        .vid_lock   (vid_lock),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .irq_o      (irq_o)
    );

    // driver side: issue a read and queue what it must return
    task automatic exp_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_rd   = 1'b1;
        reg_addr = a;
        it.a = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_chk++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s irq_o actual %0b expected %0b", tag, irq_o, e);
        end
    endtask

    // one line: sync for 2 cycles, then act enable cycles, tot cycles overall
    task automatic vline(input int tot, input int act, input bit vs, input bit f);
        for (int c = 0; c < tot; c++) begin
            @(negedge clk);
            vid_hs  = (c < 2);
            vid_vs  = vs && (c < 2);
            vid_fld = f;
            vid_de  = (act > 0) && (c >= 2) && (c < 2 + act);
        end
    endtask

    // monitor: compare every returned word against the queue head
    always @(negedge clk) begin
        if (!rst && reg_rvalid) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected read data actual %0h expected none", reg_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (reg_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr %0d actual %0h expected %0h", it.tag, it.a, reg_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        rst = 1'b1; vid_de = 0; vid_hs = 0; vid_vs = 0; vid_fld = 0; vid_lock = 1;
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // reset state and defaults (R7, R6)
        exp_rd(A_STAT, 32'h0, "R6 status after reset");
        exp_rd(A_ACT_SAMP, 32'd1920, "R7 default active samples");
        exp_rd(A_TOT_SAMP, 32'd2200, "R7 default total samples");
        exp_rd(A_F0_TOT, 32'd563, "R7 default f0 total lines");
        exp_rd(A_F1_TOT, 32'd562, "R7 default f1 total lines");
        exp_rd(A_IRQ, 32'h0, "R8 pending after reset");
        chk_irq(1'b0, "R9 reset");
        wr(A_CTRL, 32'h6);
        exp_rd(A_CTRL, 32'h6, "R9 control readback");

        // two fields of opposite polarity, blanking lines first (R3 R4 R5 R6 R1 R8)
        vline(12, 0, 1, 0); vline(12, 0, 0, 0);
        for (int i = 0; i < 3; i++) vline(12, 8, 0, 0);
        vline(12, 0, 1, 1); vline(12, 0, 0, 1);
        for (int i = 0; i < 2; i++) vline(12, 8, 0, 1);
        vline(12, 0, 1, 0);
        exp_rd(A_STAT, 32'h3F, "R5 interlaced, resolution and all valid");
        exp_rd(A_ACT_SAMP, 32'd8, "R3 active samples");
        exp_rd(A_TOT_SAMP, 32'd12, "R3 total samples");
        exp_rd(A_F0_ACT, 32'd3, "R4 f0 active lines");
        exp_rd(A_F0_TOT, 32'd5, "R4 f0 total lines");
        exp_rd(A_F1_ACT, 32'd2, "R4 f1 active lines");
        exp_rd(A_F1_TOT, 32'd4, "R4 f1 total lines");
        exp_rd(A_IRQ, 32'h6, "R8 both pending");
        chk_irq(1'b1, "R9 both enabled");

        // write-one-to-clear (R10)
        wr(A_IRQ, 32'h2);
        exp_rd(A_IRQ, 32'h4, "R10 clear update only");
        chk_irq(1'b1, "R9 stability still pending");
        wr(A_IRQ, 32'h4);
        chk_irq(1'b0, "R10 all cleared");

        // line length change: long, 14, 14, 14 completed (R1 R3 R8)
        for (int i = 0; i < 4; i++) vline(14, 8, 0, 0);
        exp_rd(A_TOT_SAMP, 32'd14, "R3 new total");
        exp_rd(A_STAT, 32'h3F, "R1 stable after two equal lines");
        exp_rd(A_IRQ, 32'h6, "R8 change and stability toggles");
        wr(A_IRQ, 32'h6);

        // all-different history: unstable (R1 R8)
        vline(10, 8, 0, 0); vline(11, 8, 0, 0); vline(13, 8, 0, 0); vline(9, 8, 0, 0);
        exp_rd(A_STAT, 32'h3E, "R1 unstable with three different lengths");
        exp_rd(A_IRQ, 32'h6, "R8 stability fell");
        wr(A_IRQ, 32'h6);

        // independent enables (R9)
        wr(A_CTRL, 32'h0);
        for (int i = 0; i < 3; i++) vline(7, 4, 0, 0);
        exp_rd(A_STAT, 32'h3F, "R1 stable again");
        exp_rd(A_IRQ, 32'h6, "R8 pending while masked");
        chk_irq(1'b0, "R9 all masked");
        wr(A_CTRL, 32'h4);
        chk_irq(1'b1, "R9 stability only enabled");
        wr(A_CTRL, 32'h2);
        chk_irq(1'b1, "R9 update only enabled");
        wr(A_IRQ, 32'h2);
        chk_irq(1'b0, "R9 enabled source cleared, other masked");
        exp_rd(A_IRQ, 32'h4, "R10 only update cleared");
        wr(A_IRQ, 32'h4);
        wr(A_CTRL, 32'h6);

        // loss of lock, activity ignored (R2 R7)
        @(negedge clk); vid_lock = 1'b0;
        for (int i = 0; i < 3; i++) vline(12, 8, i == 0, 0);
        exp_rd(A_STAT, 32'h0, "R2 all flags cleared while unlocked");
        exp_rd(A_ACT_SAMP, 32'd1920, "R7 default after lock loss");
        exp_rd(A_F0_ACT, 32'd540, "R7 default f0 active lines");
        exp_rd(A_IRQ, 32'h4, "R8 stability fell on lock loss");
        chk_irq(1'b1, "R9 lock-loss interrupt");
        wr(A_IRQ, 32'h4);

        // relock and restart (R2 R6 R1)
        @(negedge clk); vid_lock = 1'b1;
        vline(12, 8, 0, 0); vline(12, 8, 0, 0);
        exp_rd(A_STAT, 32'h8, "R2 one line after relock");
        exp_rd(A_TOT_SAMP, 32'd12, "R3 total after relock");
        for (int i = 0; i < 3; i++) vline(12, 8, 0, 0);
        exp_rd(A_STAT, 32'h9, "R1 stable after relock");
        exp_rd(A_IRQ, 32'h4, "R8 stability rose, no update without resolution");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R11 reads outstanding actual %0d expected 0", sb_q.size());
        end
        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule